// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt request lines from peripherals into numbered groups. Each group owns one programmable priority register. That register holds a two-bit service level and a 14-bit handler offset. The controller registers the request lines once on entry. A group counts as pending while any of its lines is high. For each of the four levels, the controller works out which pending group should be serviced.

The core side sees three outputs:
- a valid flag;
- the highest level that has a pending group;
- the handler offset of the group that wins at that level.

Software reads a cause register for that level to learn the winning group number. It then reads that group's request register to find the active line. A request may fall away between the core being signalled and these reads. The registers then show an empty request word, and software is expected to treat that as a spurious interrupt.

Register access uses a simple 32-bit bus:
- `bus_sel_i` qualifies every access and `bus_wr_i` picks write or read.
- Read data is combinational from the address in the same cycle.
- Writes take effect at the next clock edge.
- The byte address is 10 bits wide, and bits 1:0 are ignored.

Top module: `grp_intc`

## Requirements
- R1: After reset, every populated group's priority register reads level 0 with handler offset `RST_VEC` (default 14'h0040), and `irq_valid_o` is 0.
- R2: The priority register of group g sits at byte address g*4. Bits 31:30 hold the level, bits 13:0 hold the handler offset, and bits 29:14 always read 0. A write is visible on a read in the following cycle.
- R3: The request register of group g sits at byte address 0x100 + g*4. Bit i reads as request line i of that group (input bit g*LINES+i), delayed by one clock through the input register. Bits at and above LINES read 0. Writes to request registers are ignored.
- R4: The cause register of level n sits at byte address 0x20C - n*4, so addresses 0x20C, 0x208, 0x204 and 0x200 serve levels 0, 1, 2 and 3. Bits 5:0 give the highest-numbered pending group whose level is n. All other bits read 0.
- R5: A cause register reads 0 while no group of its level is pending.
- R6: `irq_valid_o` is 1 exactly when at least one group is pending. `irq_level_o` then gives the highest level with a pending group, where level 3 is the most urgent and level 0 the least.
- R7: While `irq_valid_o` is 1, `irq_vec_o` equals the handler offset of the group that the cause register of `irq_level_o` reports. While it is 0, `irq_vec_o` is 0.
- R8: Registers of unpopulated groups (numbers NGROUPS..63) read 0, and writes to them have no effect. Any address outside the three register windows reads 0, and so does any cycle that is not a read.
- R9: When every request line of a group drops, the group stops being pending one clock later. If that empties the controller, `irq_valid_o` falls, and the group's request register and cause entry read 0 from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| req_i | input | NGROUPS*LINES | Request lines, group g at bits g*LINES +: LINES |
| irq_valid_o | output | 1 | Some group is pending |
| irq_level_o | output | 2 | Highest pending level |
| irq_vec_o | output | 14 | Handler offset of the winning group |

## Verification
The checker covers four things on every cycle:
- the valid flag agrees with the OR of all group pending bits;
- the reported level is the top level with an arbitration hit;
- no level hits while nothing is pending;
- the priority registers stay stable without a write.

It also ties the input register's one-cycle delay to the valid flag, in both the rising and falling directions. Other behaviour can only be shown by the bench's scenarios, comparing against its reference model:
- which group wins when several share a level;
- the exact cause-register addressing per level;
- that request-register writes are discarded;
- the zero reads from unpopulated groups;
- the empty request word after a one-cycle request.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;
  localparam int NLEVELS    = 4;
  localparam int LVL_W      = 2;
  localparam int VEC_W      = 14;
  localparam int MAX_GROUPS = 64;
  localparam int GRP_W      = $clog2(MAX_GROUPS);
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 32;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } prio_t;

  // address windows selected by bus_addr[9:8]
  localparam logic [1:0] WIN_PRIO  = 2'b00;
  localparam logic [1:0] WIN_REQ   = 2'b01;
  // cause window: bus_addr[9:4] == 6'b100000 (0x200..0x20F)
  localparam logic [5:0] WIN_CAUSE = 6'b100000;
endpackage

// File: rtl/grp_intc_rst_sync.sv
module grp_intc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/grp_intc_req_reg.sv
module grp_intc_req_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] req_q_o
);
  logic [W-1:0] req_q;
  logic [W-1:0] req_d;
  logic         cap_en;

  assign cap_en = 1'b1;

  always_comb begin
    req_d = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
    end else if (cap_en) begin
      req_q <= req_d;
    end
  end

  assign req_q_o = req_q;
endmodule

// File: rtl/grp_intc_prio_regs.sv
module grp_intc_prio_regs
  import grp_intc_pkg::*;
#(
  parameter int               NGROUPS = 19,
  parameter logic [VEC_W-1:0] RST_VEC = 14'h0040
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [GRP_W-1:0]          wr_grp_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output prio_t [NGROUPS-1:0]       prio_o
);
  prio_t wr_val;
  logic  unused_wbits;

  assign wr_val       = '{lvl: wdata_i[31:30], vec: wdata_i[VEC_W-1:0]};
  assign unused_wbits = ^wdata_i[29:VEC_W];

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    prio_t prio_q;
    prio_t prio_d;
    logic  hit_en;

    assign hit_en = wr_en_i && (wr_grp_i == GRP_W'(g));

    always_comb begin
      prio_d = prio_q;
      if (hit_en) begin
        prio_d = wr_val;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q <= '{lvl: '0, vec: RST_VEC};
      end else if (hit_en) begin
        prio_q <= prio_d;
      end
    end

    assign prio_o[g] = prio_q;
  end
endmodule

// File: rtl/grp_intc_arb.sv
module grp_intc_arb
  import grp_intc_pkg::*;
#(
  parameter int NGROUPS = 19
) (
  input  logic [NGROUPS-1:0]               pend_i,
  input  prio_t [NGROUPS-1:0]              prio_i,
  output logic [NLEVELS-1:0]               hit_o,
  output logic [NLEVELS-1:0][GRP_W-1:0]    win_o,
  output logic                             valid_o,
  output logic [LVL_W-1:0]                 level_o,
  output logic [VEC_W-1:0]                 vec_o
);
  // per-level search: the last matching group in ascending order wins,
  // so the highest group number takes the level
  for (genvar l = 0; l < NLEVELS; l++) begin : g_lvl
    always_comb begin
      hit_o[l] = 1'b0;
      win_o[l] = '0;
      for (int g = 0; g < NGROUPS; g++) begin
        if (pend_i[g] && (prio_i[g].lvl == LVL_W'(l))) begin
          hit_o[l] = 1'b1;
          win_o[l] = GRP_W'(g);
        end
      end
    end
  end

  logic [GRP_W-1:0] sel_grp;

  always_comb begin
    valid_o = |hit_o;
    level_o = '0;
    for (int l = 0; l < NLEVELS; l++) begin
      if (hit_o[l]) begin
        level_o = LVL_W'(l);
      end
    end
    sel_grp = win_o[level_o];
    vec_o   = '0;
    if (valid_o) begin
      for (int g = 0; g < NGROUPS; g++) begin
        if (sel_grp == GRP_W'(g)) begin
          vec_o = prio_i[g].vec;
        end
      end
    end
  end
endmodule

// File: rtl/grp_intc_rdmux.sv
module grp_intc_rdmux
  import grp_intc_pkg::*;
#(
  parameter int NGROUPS = 19,
  parameter int LINES   = 10
) (
  input  logic                           sel_i,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  prio_t [NGROUPS-1:0]            prio_i,
  input  logic [NGROUPS*LINES-1:0]       req_q_i,
  input  logic [NLEVELS-1:0]             hit_i,
  input  logic [NLEVELS-1:0][GRP_W-1:0]  win_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [GRP_W-1:0] grp;
  logic [LVL_W-1:0] cause_lvl;
  logic             unused_lsb;

  assign grp        = addr_i[GRP_W+1:2];
  // level n at 0x20C - 4n: word index 3 maps to level 0
  assign cause_lvl  = ~addr_i[3:2];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if (addr_i[9:8] == WIN_PRIO) begin
        for (int g = 0; g < NGROUPS; g++) begin
          if (grp == GRP_W'(g)) begin
            rdata_o = {prio_i[g].lvl, 16'b0, prio_i[g].vec};
          end
        end
      end else if (addr_i[9:8] == WIN_REQ) begin
        for (int g = 0; g < NGROUPS; g++) begin
          if (grp == GRP_W'(g)) begin
            rdata_o = DATA_W'(req_q_i[g*LINES +: LINES]);
          end
        end
      end else if (addr_i[9:4] == WIN_CAUSE) begin
        if (hit_i[cause_lvl]) begin
          rdata_o = DATA_W'(win_i[cause_lvl]);
        end
      end
    end
  end
endmodule

// File: rtl/grp_intc.sv
module grp_intc
  import grp_intc_pkg::*;
#(
  parameter int               NGROUPS = 19,
  parameter int               LINES   = 10,
  parameter logic [VEC_W-1:0] RST_VEC = 14'h0040
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_sel_i,
  input  logic                     bus_wr_i,
  input  logic [9:0]               bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  output logic [31:0]              bus_rdata_o,
  input  logic [NGROUPS*LINES-1:0] req_i,
  output logic                     irq_valid_o,
  output logic [1:0]               irq_level_o,
  output logic [13:0]              irq_vec_o
);
  localparam int REQ_W = NGROUPS * LINES;

  logic                          rst_n;
  logic [REQ_W-1:0]              req_q;
  logic [NGROUPS-1:0]            pend;
  prio_t [NGROUPS-1:0]           prio;
  logic [NLEVELS-1:0]            hit;
  logic [NLEVELS-1:0][GRP_W-1:0] win;
  logic                          prio_wr;

  grp_intc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  grp_intc_req_reg #(.W(REQ_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .req_i   (req_i),
    .req_q_o (req_q)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_pend
    assign pend[g] = |req_q[g*LINES +: LINES];
  end

  assign prio_wr = bus_sel_i && bus_wr_i && (bus_addr_i[9:8] == WIN_PRIO);

  grp_intc_prio_regs #(.NGROUPS(NGROUPS), .RST_VEC(RST_VEC)) u_prio (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (prio_wr),
    .wr_grp_i (bus_addr_i[GRP_W+1:2]),
    .wdata_i  (bus_wdata_i),
    .prio_o   (prio)
  );

  grp_intc_arb #(.NGROUPS(NGROUPS)) u_arb (
    .pend_i  (pend),
    .prio_i  (prio),
    .hit_o   (hit),
    .win_o   (win),
    .valid_o (irq_valid_o),
    .level_o (irq_level_o),
    .vec_o   (irq_vec_o)
  );

  grp_intc_rdmux #(.NGROUPS(NGROUPS), .LINES(LINES)) u_rd (
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .prio_i  (prio),
    .req_q_i (req_q),
    .hit_i   (hit),
    .win_i   (win),
    .rdata_o (bus_rdata_o)
  );
endmodule

// File: rtl/grp_intc_chk.sv
module grp_intc_chk
  import grp_intc_pkg::*;
#(
  parameter int NGROUPS = 19,
  parameter int LINES   = 10
) (
  input logic                     clk_i,
  input logic                     rst_n,
  input logic [NGROUPS*LINES-1:0] req_i,
  input logic [NGROUPS-1:0]       pend,
  input logic [NLEVELS-1:0]       hit,
  input logic                     irq_valid_o,
  input logic [LVL_W-1:0]         irq_level_o,
  input logic                     bus_sel_i,
  input logic                     bus_wr_i,
  input prio_t [NGROUPS-1:0]      prio
);
  // R6: valid flag follows the pending bits of the groups
  a_r6_valid_pending: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_valid_o == (|pend));

  // R6: reported level is the topmost level with a hit
  a_r6_level_top: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_valid_o |-> ((hit >> irq_level_o) == 4'b0001));

  // R5: no level hits while nothing is pending
  a_r5_no_hit_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|pend) |-> (hit == '0));

  // R3: one-cycle input register delay towards the core
  a_r3_sync_rise: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|req_i) |=> irq_valid_o);

  // R9: dropping all requests clears the valid flag a cycle later
  a_r9_sync_fall: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|req_i) |=> !irq_valid_o);

  // R2: priority registers only change on a bus write
  a_r2_prio_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(bus_sel_i && bus_wr_i) |=> $stable(prio));
endmodule

bind grp_intc grp_intc_chk #(.NGROUPS(NGROUPS), .LINES(LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .pend        (pend),
  .hit         (hit),
  .irq_valid_o (irq_valid_o),
  .irq_level_o (irq_level_o),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .prio        (prio)
);

// File: tb/grp_intc_test.sv
module grp_intc_test;
  localparam int NG = 19;
  localparam int LN = 10;
  localparam int RW = NG * LN;
  localparam logic [13:0] RVEC = 14'h0040;

  logic          clk;
  logic          rst_n;
  logic          sel, wr;
  logic [9:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [RW-1:0] req;
  logic          ivalid;
  logic [1:0]    ilevel;
  logic [13:0]   ivec;

  grp_intc #(.NGROUPS(NG), .LINES(LN), .RST_VEC(RVEC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .req_i(req), .irq_valid_o(ivalid), .irq_level_o(ilevel), .irq_vec_o(ivec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 0;
  string cur_tag = "R2";

  // reference model state
  int m_lvl[NG];
  int m_vec[NG];
  logic [RW-1:0] m_req;

  function automatic bit m_pend(int g);
    return (m_req[g*LN +: LN] != '0);
  endfunction

  function automatic int m_cause(int lv);
    for (int g = NG - 1; g >= 0; g--)
      if (m_pend(g) && m_lvl[g] == lv) return g;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [9:0] a);
    int g, lv, c;
    g = int'(a[7:2]);
    if (a < 10'h100) begin
      if (g < NG) return {m_lvl[g][1:0], 16'b0, m_vec[g][13:0]};
      return 0;
    end else if (a < 10'h200) begin
      if (g < NG) return 32'(m_req[g*LN +: LN]);
      return 0;
    end else if (a >= 10'h200 && a <= 10'h20F) begin
      lv = 3 - int'(a[3:2]);
      c = m_cause(lv);
      return (c < 0) ? 32'd0 : 32'(c);
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_lvl[g] = 0; m_vec[g] = int'(RVEC); end
      m_req = '0;
    end else begin
      m_req = req;
      if (sel && wr && addr < 10'h100 && int'(addr[7:2]) < NG) begin
        m_lvl[addr[7:2]] = int'(wdata[31:30]);
        m_vec[addr[7:2]] = int'(wdata[13:0]);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      int top, c;
      logic [13:0] ev;
      top = -1;
      for (int lv = 3; lv >= 0 && top < 0; lv--)
        if (m_cause(lv) >= 0) top = lv;
      check("R6", {31'b0, ivalid}, {31'b0, top >= 0});
      if (top >= 0) begin
        check("R6", {30'b0, ilevel}, 32'(top));
        c = m_cause(top);
        ev = m_vec[c][13:0];
      end else ev = 14'h0;
      check("R7", {18'b0, ivec}, {18'b0, ev});
      if (sel && !wr) check(cur_tag, rdata, m_read(addr));
      else check("R8", rdata, 32'h0);
    end
  end

  task automatic rd(logic [9:0] a, string tag);
    @(posedge clk); #1;
    sel = 1; wr = 0; addr = a; cur_tag = tag;
    @(posedge clk); #1;
    sel = 0;
  endtask

  task automatic wrr(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #1;
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 0; wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_group(int g, logic [LN-1:0] v);
    @(posedge clk); #1;
    req[g*LN +: LN] = v;
  endtask

  logic [31:0] lf = 32'h1ACE_B00C;

  task automatic rand_req();
    @(posedge clk); #1;
    for (int g = 0; g < NG; g++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      req[g*LN +: LN] = (lf[3:0] < 4'd3) ? lf[13:4] : '0;
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    sel = 0; wr = 0; addr = '0; wdata = '0; req = '0;
    rst_n = 0;
    idle(3);
    #1 rst_n = 1;
    idle(4);
    cmp_en = 1;

    // R1: reset state of the priority registers
    for (int g = 0; g < NG; g++) rd(10'(g * 4), "R1");
    check("R1", {31'b0, ivalid}, 32'h0);

    // R2: program levels and offsets
    for (int g = 0; g < NG; g++)
      wrr(10'(g * 4), {2'(g % 4), 16'hFFFF, 14'(16'h100 + g * 3)});
    for (int g = 0; g < NG; g++) rd(10'(g * 4), "R2");

    // R5: all cause registers empty
    for (int lv = 0; lv < 4; lv++) rd(10'(12'h20C - lv * 4), "R5");

    // R4: several groups at one level, highest number wins
    set_group(1, 10'h001);   // level 1
    set_group(5, 10'h020);   // level 1
    set_group(9, 10'h200);   // level 1
    idle(2);
    rd(10'h208, "R4");
    rd(10'h200, "R5");
    set_group(4, 10'h004);   // level 0
    set_group(14, 10'h080);  // level 2
    idle(2);
    rd(10'h20C, "R4");
    rd(10'h204, "R4");
    set_group(3, 10'h3FF);   // level 3
    idle(2);
    rd(10'h200, "R4");

    // R3: request registers and ignored writes
    for (int g = 0; g < 6; g++) rd(10'(10'h100 + g * 4), "R3");
    wrr(10'h114, 32'hFFFF_FFFF);
    rd(10'h114, "R3");
    wrr(10'h104, 32'h0);
    rd(10'h104, "R3");

    // R9: short request and drop
    req = '0;
    idle(2);
    set_group(7, 10'h002);
    set_group(7, 10'h000);
    rd(10'h11C, "R9");
    rd(10'h204, "R9");
    check("R9", {31'b0, ivalid}, 32'h0);

    // R8: unpopulated group and unmapped addresses
    wrr(10'h078, 32'hC000_1234);
    rd(10'h078, "R8");
    rd(10'h178, "R8");
    rd(10'h210, "R8");
    rd(10'h3FC, "R8");

    // R2: reprogram under load, R6/R7 via the per-cycle compare
    for (int k = 0; k < 120; k++) begin
      rand_req();
      if (k % 5 == 0) wrr(10'((k % NG) * 4), {lf[1:0], 16'h0, lf[29:16]});
      rd(10'(10'h200 + (k % 4) * 4), "R4");
      rd(10'(10'h100 + (k % NG) * 4), "R3");
    end
    req = '0;
    idle(3);

    cmp_en = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule